// File: doc/BRIEF.md
# DDR SDRAM Low-Power State Sequencer

This block sits on the controller side of a DDR SDRAM interface. It moves the memory into self refresh or power-down and brings it back out. It owns the clock-enable pin and the four command pins (chip select, row strobe, column strobe, write enable) whenever a low-power transition is in progress. Host logic raises a self-refresh request or a power-down request. It also raises a wake request when it wants the memory back. The sequencer tells the host when plain commands may be issued again and, separately, when reads may be issued again.

On power-down entry the sequencer samples the per-bank open-row flags. It reports whether this is an active power-down (some row open) or a precharge power-down (all banks idle). It also samples whether the DLL was switched off for this power-down, and if so it applies a long read wait on exit. A refresh-deadline counter bounds the time spent in power-down and forces an exit before the refresh interval runs out. Self refresh has no such bound, because the memory refreshes itself. After leaving self refresh, separate wait counters hold off non-read commands and reads.

Top module: `ddr_lp_seq`

## Requirements
- R1: After reset, `cke` is 1, the command pins carry NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), `ready_cmd` and `ready_rd` are 1, and `busy` is 0.
- R2: When `sref_req` is seen in the idle state with `acc_busy` low, the next cycle drives `cke`=0 with cs_n=0, ras_n=0, cas_n=0, we_n=1 for exactly one cycle. After that cycle the pins carry NOP while `cke` stays 0 and `in_sref`=1. If both requests are present, `sref_req` wins over `pdn_req`.
- R3: In self refresh, `pdn_req`, `sref_req`, `bank_open`, `dll_off` and `acc_busy` have no effect. `cke` stays 0 until `wake_req`, however long that takes.
- R4: On `wake_req` in self refresh, the next cycle drives `cke`=1 with NOP. `ready_cmd` rises T_XSNR cycles after that first high-`cke` cycle, and `ready_rd` rises T_XSRD cycles after it.
- R5: When `pdn_req` is seen in the idle state with `acc_busy` low, the next cycle drives `cke`=0 with NOP and `in_pdn`=1. If `acc_busy` is high, no entry happens and `cke` stays 1.
- R6: During power-down, `pdn_active` equals the OR of `bank_open` sampled at entry (1 = active power-down, 0 = precharge power-down), and it holds steady.
- R7: On `wake_req` in power-down, the next cycle drives `cke`=1 with NOP. `ready_cmd` rises one cycle after that. `ready_rd` also rises one cycle after, unless `dll_off` was high at entry, in which case it rises T_DLL cycles after.
- R8: Without a wake request, power-down keeps `cke` low for exactly T_REFI cycles and then exits on its own, with the same waits as R7.
- R9: `busy` is 1 and `ready_cmd` is 0 from the entry cycle through every low-`cke` cycle. `busy` stays 1 until all exit waits have finished. Low-power requests made while the exit wait runs are ignored, and `wake_req` in the idle state is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sref_req | input | 1 | Request self refresh entry |
| pdn_req | input | 1 | Request power-down entry |
| wake_req | input | 1 | Request exit from the current low-power state |
| dll_off | input | 1 | DLL is disabled for this power-down (sampled at entry) |
| acc_busy | input | 1 | An access is in progress; blocks entry |
| bank_open | input | NB | Per-bank open-row flags |
| cke | output | 1 | Clock enable to memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ready_cmd | output | 1 | Non-read commands may be issued |
| ready_rd | output | 1 | Reads may be issued |
| busy | output | 1 | Low-power state or exit wait in progress |
| in_sref | output | 1 | Memory is in self refresh |
| in_pdn | output | 1 | Memory is in power-down |
| pdn_active | output | 1 | 1 = active power-down, 0 = precharge power-down |

## Verification
The assertions check, on every cycle, several rules. Command pins carry NOP on every rising edge of clock enable. The self-refresh code appears on the falling edge into self refresh. Entry never follows a cycle with an access in progress. Neither ready flag is high while clock enable is low. Read readiness never comes before command readiness. The power-down mode flag stays steady. A checker counter keeps power-down within the refresh deadline. The exact lengths of the exit waits can only be shown by the bench's scenarios. So can the DLL-off read delay, the forced exit at the deadline, and the way stray requests are ignored during self refresh and the exit wait. The bench sweeps every open-bank pattern against both DLL settings for this.

// File: rtl/lp_pkg.sv
package lp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SREF = 2'd1,
        ST_PDN  = 2'd2,
        ST_EXIT = 2'd3
    } lp_state_e;

    typedef enum logic {
        CMD_NOP  = 1'b0,
        CMD_SREF = 1'b1
    } lp_cmd_e;

    localparam int WAIT_CMD = 0;
    localparam int WAIT_RD  = 1;
    localparam int N_WAITS  = 2;
endpackage

// File: rtl/lp_wait_cnt.sv
module lp_wait_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/lp_cmd_enc.sv
module lp_cmd_enc
    import lp_pkg::*;
(
    input  lp_cmd_e cmd,
    output logic    cs_n,
    output logic    ras_n,
    output logic    cas_n,
    output logic    we_n
);
    always_comb begin
        cs_n = 1'b0;
        we_n = 1'b1;
        unique case (cmd)
            CMD_SREF: begin ras_n = 1'b0; cas_n = 1'b0; end
            default:  begin ras_n = 1'b1; cas_n = 1'b1; end
        endcase
    end
endmodule

// File: rtl/ddr_lp_seq.sv
module ddr_lp_seq
    import lp_pkg::*;
#(
    parameter int NB     = 4,
    parameter int T_XSRD = 200,
    parameter int T_XSNR = 10,
    parameter int T_DLL  = 200,
    parameter int T_REFI = 7800
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sref_req,
    input  logic          pdn_req,
    input  logic          wake_req,
    input  logic          dll_off,
    input  logic          acc_busy,
    input  logic [NB-1:0] bank_open,
    output logic          cke,
    output logic          cs_n,
    output logic          ras_n,
    output logic          cas_n,
    output logic          we_n,
    output logic          ready_cmd,
    output logic          ready_rd,
    output logic          busy,
    output logic          in_sref,
    output logic          in_pdn,
    output logic          pdn_active
);
    localparam int WMAX_A = (T_XSRD > T_XSNR) ? T_XSRD : T_XSNR;
    localparam int WMAX   = (WMAX_A > T_DLL) ? WMAX_A : T_DLL;
    localparam int WW     = $clog2(WMAX + 1);
    localparam int RW     = $clog2(T_REFI + 1);

    typedef struct packed {
        lp_state_e     st;
        lp_cmd_e       cmd;
        logic          cke;
        logic          pd_act;
        logic          dll_dis;
        logic [RW-1:0] pd_cnt;
    } seq_t;

    seq_t s_d, s_q;

    logic                 wait_load;
    logic [WW-1:0]        wait_val [N_WAITS];
    logic [N_WAITS-1:0]   wait_zero;

    always_comb begin
        s_d       = s_q;
        s_d.cmd   = CMD_NOP;
        wait_load = 1'b0;
        for (int i = 0; i < N_WAITS; i++) wait_val[i] = '0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (sref_req && !acc_busy) begin
                    s_d.st  = ST_SREF;
                    s_d.cke = 1'b0;
                    s_d.cmd = CMD_SREF;
                end else if (pdn_req && !acc_busy) begin
                    s_d.st      = ST_PDN;
                    s_d.cke     = 1'b0;
                    s_d.pd_act  = |bank_open;
                    s_d.dll_dis = dll_off;
                    s_d.pd_cnt  = '0;
                end
            end
            ST_SREF: begin
                if (wake_req) begin
                    s_d.st             = ST_EXIT;
                    s_d.cke            = 1'b1;
                    wait_load          = 1'b1;
                    wait_val[WAIT_CMD] = WW'(T_XSNR);
                    wait_val[WAIT_RD]  = WW'(T_XSRD);
                end
            end
            ST_PDN: begin
                if (wake_req || s_q.pd_cnt == RW'(T_REFI - 1)) begin
                    s_d.st             = ST_EXIT;
                    s_d.cke            = 1'b1;
                    wait_load          = 1'b1;
                    wait_val[WAIT_CMD] = WW'(1);
                    wait_val[WAIT_RD]  = s_q.dll_dis ? WW'(T_DLL) : WW'(1);
                end else begin
                    s_d.pd_cnt = s_q.pd_cnt + 1'b1;
                end
            end
            default: begin
                if (&wait_zero) s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.st      <= ST_IDLE;
            s_q.cmd     <= CMD_NOP;
            s_q.cke     <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar g = 0; g < N_WAITS; g++) begin : g_wait
        lp_wait_cnt #(.W(WW)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (wait_load),
            .load_val (wait_val[g]),
            .zero     (wait_zero[g])
        );
    end

    lp_cmd_enc u_enc (
        .cmd   (s_q.cmd),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n)
    );

    assign cke        = s_q.cke;
    assign busy       = (s_q.st != ST_IDLE);
    assign in_sref    = (s_q.st == ST_SREF);
    assign in_pdn     = (s_q.st == ST_PDN);
    assign pdn_active = s_q.pd_act;
    assign ready_cmd  = (s_q.st == ST_IDLE) || (s_q.st == ST_EXIT && wait_zero[WAIT_CMD]);
    assign ready_rd   = (s_q.st == ST_IDLE) || (s_q.st == ST_EXIT && wait_zero[WAIT_RD]);
endmodule

// File: rtl/ddr_lp_seq_chk.sv
module ddr_lp_seq_chk #(
    parameter int T_REFI = 7800
) (
    input logic clk,
    input logic rst_n,
    input logic acc_busy,
    input logic cke,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic ready_cmd,
    input logic ready_rd,
    input logic busy,
    input logic in_sref,
    input logic in_pdn,
    input logic pdn_active
);
    int pd_run;

    always_ff @(posedge clk) begin
        if (!rst_n)      pd_run <= 0;
        else if (in_pdn) pd_run <= pd_run + 1;
        else             pd_run <= 0;
    end

    AST_SREF_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cke) && in_sref) |-> (!cs_n && !ras_n && !cas_n && we_n)); // R2
    AST_EXIT_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (!cs_n && ras_n && cas_n && we_n && !ready_cmd && !ready_rd)); // R4
    AST_NO_ENTRY_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> !$past(acc_busy)); // R5
    AST_MODE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pdn && $past(in_pdn)) |-> $stable(pdn_active)); // R6
    AST_RD_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        ready_rd |-> ready_cmd); // R7
    AST_REFRESH_DEADLINE: assert property (@(posedge clk) disable iff (!rst_n)
        in_pdn |-> (pd_run < T_REFI)); // R8
    AST_LOWPWR_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (busy && !ready_cmd && !ready_rd)); // R9
endmodule

bind ddr_lp_seq ddr_lp_seq_chk #(.T_REFI(T_REFI)) u_chk (.*);

// File: tb/ddr_lp_seq_tb.sv
`timescale 1ns/1ps
module ddr_lp_seq_tb;
    localparam int NB = 4, XSRD = 6, XSNR = 3, DLLW = 9, REFI = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sref_req = 0, pdn_req = 0, wake_req = 0, dll_off = 0, acc_busy = 0;
    logic [NB-1:0] bank_open = '0;
    logic cke, cs_n, ras_n, cas_n, we_n, ready_cmd, ready_rd, busy, in_sref, in_pdn, pdn_active;
    int checks = 0, failures = 0;

    always #10 clk = ~clk;

    ddr_lp_seq #(.NB(NB), .T_XSRD(XSRD), .T_XSNR(XSNR), .T_DLL(DLLW), .T_REFI(REFI)) u_dut (
        .clk(clk), .rst_n(rst_n), .sref_req(sref_req), .pdn_req(pdn_req), .wake_req(wake_req),
        .dll_off(dll_off), .acc_busy(acc_busy), .bank_open(bank_open), .cke(cke), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ready_cmd(ready_cmd), .ready_rd(ready_rd),
        .busy(busy), .in_sref(in_sref), .in_pdn(in_pdn), .pdn_active(pdn_active));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pins();
        return {cs_n, ras_n, cas_n, we_n};
    endfunction

    // called at the negedge right after the exit edge
    task automatic measure(input string req, input int exp_cmd, input int exp_rd);
        int nc = -1, nr = -1;
        chk({req, " cke high on exit"}, cke, 1);
        chk({req, " NOP on exit"}, pins(), 4'b0111);
        for (int n = 0; n < 60; n++) begin
            if (ready_cmd && nc < 0) nc = n;
            if (ready_rd && nr < 0) nr = n;
            if (nc >= 0 && nr >= 0) break;
            @(negedge clk);
        end
        chk({req, " cmd wait"}, nc, exp_cmd);
        chk({req, " read wait"}, nr, exp_rd);
        repeat (3) @(negedge clk);
        chk({req, " busy clears (R9)"}, busy, 0);
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int lowc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cke", cke, 1);
        chk("R1 pins NOP", pins(), 4'b0111);
        chk("R1 ready_cmd", ready_cmd, 1);
        chk("R1 ready_rd", ready_rd, 1);
        chk("R1 busy", busy, 0);

        // R9 wake in idle ignored
        wake_req = 1; @(negedge clk); wake_req = 0;
        chk("R9 idle wake ignored cke", cke, 1);
        chk("R9 idle wake ignored busy", busy, 0);

        // R5 access in progress blocks entry
        acc_busy = 1; pdn_req = 1; sref_req = 1;
        @(negedge clk);
        chk("R5 blocked by access", cke, 1);
        acc_busy = 0; pdn_req = 0; sref_req = 0;

        // R2 self refresh entry, priority over pdn_req
        sref_req = 1; pdn_req = 1;
        @(negedge clk);
        sref_req = 0; pdn_req = 0;
        chk("R2 cke low", cke, 0);
        chk("R2 entry code", pins(), 4'b0001);
        chk("R2 sref wins", in_sref, 1);
        @(negedge clk);
        chk("R2 NOP after entry", pins(), 4'b0111);
        // R3 stray inputs ignored, no deadline
        for (int k = 0; k < 3 * REFI; k++) begin
            pdn_req = k[0]; sref_req = k[1]; acc_busy = k[2]; dll_off = k[0]; bank_open = NB'(k);
            @(negedge clk);
            if (cke != 0 || !in_sref) chk("R3 held in self refresh", {cke, in_sref}, 1);
        end
        pdn_req = 0; sref_req = 0; acc_busy = 0; dll_off = 0; bank_open = '0;
        chk("R3 still in self refresh", in_sref, 1);
        chk("R9 busy in sref", busy, 1);
        wake_req = 1; @(negedge clk); wake_req = 0;
        measure("R4 sref exit", XSNR, XSRD);

        // R9 requests during exit wait ignored
        sref_req = 1; @(negedge clk); sref_req = 0;
        @(negedge clk);
        wake_req = 1; @(negedge clk); wake_req = 0;
        pdn_req = 1; sref_req = 1;
        @(negedge clk);
        chk("R9 request during exit wait", cke, 1);
        pdn_req = 0; sref_req = 0;
        repeat (XSRD + 3) @(negedge clk);
        chk("R9 back to idle", busy, 0);

        // R5 R6 R7 sweep over bank patterns and DLL setting
        for (int d = 0; d < 2; d++) begin
            for (int b = 0; b < (1 << NB); b++) begin
                pdn_req = 1; bank_open = NB'(b); dll_off = d[0];
                @(negedge clk);
                pdn_req = 0; bank_open = ~NB'(b); dll_off = ~d[0];
                chk("R5 pdn entry cke", cke, 0);
                chk("R5 pdn NOP", pins(), 4'b0111);
                chk("R6 mode", pdn_active, (b != 0) ? 1 : 0);
                for (int h = 0; h < 1 + (b % 5); h++) @(negedge clk);
                chk("R6 mode held", pdn_active, (b != 0) ? 1 : 0);
                chk("R9 not ready in pdn", ready_cmd, 0);
                wake_req = 1; @(negedge clk); wake_req = 0;
                measure("R7 pdn exit", 1, d ? DLLW : 1);
            end
        end

        // R8 deadline forced exit
        pdn_req = 1; dll_off = 1; @(negedge clk); pdn_req = 0; dll_off = 0;
        lowc = 0;
        for (int n = 0; n < 4 * REFI && cke == 0; n++) begin
            lowc++;
            @(negedge clk);
        end
        chk("R8 low cycles", lowc, REFI);
        measure("R8 forced exit", 1, DLLW);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule